// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers sixteen interrupt request lines and presents one active-high request to a processor. Each line has its own trigger mode: active-low level, active-high level, falling edge or rising edge. Each line also has a small priority number, and a priority of zero takes the line out of arbitration. A global enable bit and a threshold register decide whether anything reaches the processor. Edge events are held in per-line latches until software clears them with a command write.

Software uses a 32-bit register bus. A write takes effect at the clock edge on which the write enable is sampled. A read returns data on the cycle after the read enable is sampled. A status word gives the winning line, its priority and a pending flag. That flag is low when a request is pending. A second word shows the raw active state of every line, so that software can poll it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `cpu_irq` is low, and the current-status word at byte offset 0xA0 reads 0x00010000.
- R2: Bit 0 of the word at offset 0x00 enables the controller. While this bit is 0, `cpu_irq` stays low and the current-status word reports nothing pending.
- R3: Line n takes its 2-bit mode from bits [2*(n%8)+1:2*(n%8)] of the word at offset 0x04 (n<8) or offset 0x08 (n>=8). Mode 00 makes the line active while its input is low. Mode 01 makes it active while its input is high.
- R4: Mode 10 (falling) and mode 11 (rising) latch the chosen edge of the input. The latch is set one clock after the edge. It stays set after the input returns, and it drops only through a clear command or a mode change to a level mode.
- R5: A write to offset 0x60 with bit 8 set clears the edge latch of the line numbered in bits [3:0]. A write to 0x60 with bit 8 clear has no effect.
- R6: The priority of line n is the low 3 bits of the byte at bit offset (n/16)*16+(n&1)*8 in the word at offset 0x10+4*((n%16)/2). The upper bits of that byte are ignored. A priority of 0 keeps the line from ever winning.
- R7: A line can win only when it is active and its priority is strictly greater than the threshold held in bits [2:0] of offset 0x40.
- R8: Among the eligible lines, the highest priority wins. When priorities are equal, the lowest line number wins.
- R9: The current-status word has the following fields. Bit 16 is 0 when a request is pending and 1 otherwise. Bits [10:8] hold the winning priority and bits [4:0] hold the winning line. Both fields read 0 when nothing is pending. `cpu_irq` is high exactly when a request is pending.
- R10: Offset 0x80 returns the raw active bit of every line in bits [15:0]. This includes lines whose priority is 0. Unused offsets and offset 0x60 read 0.
- R11: A read returns the addressed register on the cycle after `bus_re` is sampled. `bus_rdata` is 0 on the cycle after a clock edge where `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | 16 | Interrupt request lines |
| cpu_irq | output | 1 | Request to the processor |

## Verification
The bench builds the block with its defaults: sixteen lines and 3-bit priorities. With these values both mode words and all eight priority words are in use. Line 10 reaches the second mode word, and lines 2, 3 and 9 share priority words. This makes it possible to test field placement, equal-priority ties between lines in different words, and clearing one latch by number. The upper byte fields stay unused, so the check that only the low 3 priority bits count is made by writing into the ignored bits of a live field.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 16,
  parameter int LVL_W = 3,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_re,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] irq_in,
  output logic             cpu_irq
);
  localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int N_MODE = (N_SRC + 7) / 8;
  localparam int N_LVL  = 8;

  logic              en_q;
  logic [15:0]       mode_q [N_MODE];
  logic [31:0]       lvl_q  [N_LVL];
  logic [LVL_W-1:0]  thr_q;
  logic [N_SRC-1:0]  in_q, lat_q, det, act, cand, is_edge, clr_vec;
  logic [1:0]        md  [N_SRC];
  logic [LVL_W-1:0]  pri [N_SRC];
  logic              found, pend;
  logic [LVL_W-1:0]  best_lvl;
  logic [SW-1:0]     best_src;
  logic [31:0]       csr_word, rd_val;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign md[g]      = mode_q[g/8][2*(g%8) +: 2];
    assign pri[g]     = lvl_q[(g%16)/2][(g/16)*16 + (g%2)*8 +: LVL_W];
    assign is_edge[g] = md[g][1];
    assign det[g]     = md[g][0] ? (irq_in[g] & ~in_q[g]) : (~irq_in[g] & in_q[g]);
    assign act[g]     = md[g][1] ? lat_q[g] : (md[g][0] ? irq_in[g] : ~irq_in[g]);
    assign cand[g]    = act[g] && (pri[g] > thr_q);
  end

  wire clr_hit = bus_we && bus_addr == AW'('h60) && bus_wdata[8];
  assign clr_vec = clr_hit ? (N_SRC'(1) << bus_wdata[3:0]) : '0;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_src = '0;
    for (int n = 0; n < N_SRC; n++) begin
      if (cand[n] && (!found || pri[n] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = pri[n];
        best_src = SW'(n);
      end
    end
  end

  assign pend    = en_q && found;
  assign cpu_irq = pend;

  always_comb begin
    csr_word     = '0;
    csr_word[16] = ~pend;
    if (pend) begin
      csr_word[8 +: LVL_W] = best_lvl;
      csr_word[SW-1:0]     = best_src;
    end
  end

  wire lvl_hit = bus_addr >= AW'('h10) && bus_addr <= AW'('h2C) && bus_addr[1:0] == 2'b00;
  wire [2:0] lvl_idx = 3'((bus_addr - AW'('h10)) >> 2);

  always_comb begin
    rd_val = '0;
    if (lvl_hit) rd_val = lvl_q[lvl_idx];
    else begin
      case (bus_addr)
        AW'('h00): rd_val = {31'b0, en_q};
        AW'('h04): rd_val = {16'b0, mode_q[0]};
        AW'('h08): rd_val = (N_MODE > 1) ? {16'b0, mode_q[N_MODE-1]} : '0;
        AW'('h40): rd_val = 32'(thr_q);
        AW'('h80): rd_val = 32'(act);
        AW'('hA0): rd_val = csr_word;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      thr_q     <= '0;
      in_q      <= '0;
      lat_q     <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < N_MODE; i++) mode_q[i] <= '0;
      for (int i = 0; i < N_LVL; i++)  lvl_q[i]  <= '0;
    end else begin
      in_q      <= irq_in;
      lat_q     <= ((lat_q & ~clr_vec) | det) & is_edge;
      bus_rdata <= bus_re ? rd_val : '0;
      if (bus_we) begin
        if (bus_addr == AW'('h00)) en_q  <= bus_wdata[0];
        if (bus_addr == AW'('h40)) thr_q <= bus_wdata[LVL_W-1:0];
        if (bus_addr == AW'('h04)) mode_q[0] <= bus_wdata[15:0];
        if (bus_addr == AW'('h08) && N_MODE > 1) mode_q[N_MODE-1] <= bus_wdata[15:0];
        if (lvl_hit) lvl_q[lvl_idx] <= bus_wdata;
      end
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int N_SRC = 16,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_re,
  input logic [31:0]      bus_rdata,
  input logic             cpu_irq,
  input logic             en_q,
  input logic [LVL_W-1:0] thr_q,
  input logic [31:0]      csr_word,
  input logic [N_SRC-1:0] lat_q
);
  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !cpu_irq); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((lat_q & $past(lat_q)) == $past(lat_q))); // R4
  AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (csr_word[8 +: LVL_W] > thr_q)); // R7
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == !csr_word[16]); // R9
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (csr_word[4:0] < 5'(N_SRC))); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .en_q(en_q), .thr_q(thr_q),
  .csr_word(csr_word), .lat_q(lat_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '1;
  logic        cpu_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic set_in(input int idx, input logic v);
    @(negedge clk); irq_in[idx] = v;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    rd(8'h00, d); chk("R1 enable", d, 0);
    rd(8'h04, d); chk("R1 mode0", d, 0);
    rd(8'h14, d); chk("R1 level1", d, 0);
    rd(8'h40, d); chk("R1 threshold", d, 0);
    rd(8'hA0, d); chk("R1 csr", d, 32'h0001_0000);
  endtask

  task automatic t_enable_low();
    logic [31:0] d;
    wr(8'h14, 32'h0000_0500);
    set_in(3, 1'b0);
    chk("R2 disabled irq", 32'(cpu_irq), 0);
    rd(8'hA0, d); chk("R2 disabled csr", d, 32'h0001_0000);
    wr(8'h00, 32'h1);
    #1 chk("R3 low level irq", 32'(cpu_irq), 1);
    rd(8'hA0, d); chk("R9 csr src3", d, 32'h0000_0503);
    rd(8'h00, d); chk("R11 enable readback", d, 1);
  endtask

  task automatic t_high_level();
    wr(8'h04, 32'h0000_0040);
    #1 chk("R3 high mode, input low", 32'(cpu_irq), 0);
    set_in(3, 1'b1);
    chk("R3 high mode, input high", 32'(cpu_irq), 1);
    wr(8'h04, 32'h0);
    #1 chk("R3 low mode, input high", 32'(cpu_irq), 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(8'h24, 32'h0000_0003);
    wr(8'h08, 32'h0000_0030);
    set_in(10, 1'b0);
    @(negedge clk); #1 chk("R4 rising mode ignores fall", 32'(cpu_irq), 0);
    set_in(10, 1'b1);
    @(negedge clk); #1 chk("R4 rising latched", 32'(cpu_irq), 1);
    set_in(10, 1'b0);
    @(negedge clk); #1 chk("R4 latch held", 32'(cpu_irq), 1);
    rd(8'h80, d); chk("R10 raw active", d, 32'h0000_0400);
    wr(8'h60, 32'h0000_000A);
    rd(8'h80, d); chk("R5 no guard no clear", d, 32'h0000_0400);
    wr(8'h60, 32'h0000_010A);
    #1 chk("R5 cleared irq", 32'(cpu_irq), 0);
    rd(8'h80, d); chk("R5 cleared raw", d, 0);
    wr(8'h08, 32'h0000_0020);
    set_in(10, 1'b1);
    @(negedge clk); #1 chk("R4 falling mode ignores rise", 32'(cpu_irq), 0);
    set_in(10, 1'b0);
    @(negedge clk); #1 chk("R4 falling latched", 32'(cpu_irq), 1);
    rd(8'hA0, d); chk("R9 csr src10", d, 32'h0000_030A);
    wr(8'h60, 32'h0000_010A);
    #1 chk("R5 falling cleared", 32'(cpu_irq), 0);
    set_in(10, 1'b1);
    wr(8'h08, 32'h0);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(8'h14, 32'h0000_0504);
    wr(8'h20, 32'h0000_0500);
    set_in(2, 1'b0); set_in(3, 1'b0); set_in(9, 1'b0);
    rd(8'hA0, d); chk("R8 tie lowest wins", d, 32'h0000_0503);
    set_in(3, 1'b1);
    rd(8'hA0, d); chk("R8 highest wins", d, 32'h0000_0509);
    set_in(9, 1'b1);
    wr(8'h14, 32'h0000_05F4);
    rd(8'hA0, d); chk("R6 upper bits ignored", d, 32'h0000_0402);
    wr(8'h14, 32'h0000_0500);
    #1 chk("R6 priority 0 masks", 32'(cpu_irq), 0);
    rd(8'h80, d); chk("R10 raw with priority 0", d, 32'h0000_0004);
    wr(8'h14, 32'h0000_0004);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(8'h40, 32'h4);
    #1 chk("R7 equal to threshold blocked", 32'(cpu_irq), 0);
    wr(8'h40, 32'h3);
    #1 chk("R7 above threshold passes", 32'(cpu_irq), 1);
    rd(8'h40, d); chk("R11 threshold readback", d, 3);
    set_in(2, 1'b1);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    rd(8'h0C, d); chk("R10 unused 0x0C", d, 0);
    rd(8'h60, d); chk("R10 command reads 0", d, 0);
    rd(8'hFC, d); chk("R10 unused 0xFC", d, 0);
    rd(8'h14, d); chk("R11 level readback", d, 32'h0000_0004);
    @(negedge clk); chk("R11 idle rdata", bus_rdata, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_enable_low();
    t_high_level();
    t_edges();
    t_priority();
    t_threshold();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule